// File: doc/BRIEF.md
# Sample-Hold and Conversion Sequencer

This block runs the host side of an external sample-hold amplifier feeding a 12-bit successive-approximation converter. When a trigger arrives while idle, it keeps the sample control line low for an acquisition window so the hold capacitor can charge. It then switches the line to hold and waits a settling interval. After that it drives a start-convert pulse of a fixed width. The converter starts its cycle on the falling edge of that pulse.

The sequencer then watches the converter's end-of-conversion status. That status is high while the converter resets and converts, and low once the result is ready. The sequencer counts completion only after it has seen the status high at least once in the current cycle, so a low level left over from an earlier conversion is never mistaken for done. On completion it latches the 12 parallel data lines and gives a one-cycle valid strobe. The converter emits complementary coding; a per-conversion control can flip every bit to recover straight binary or offset binary.

If the status has not returned low within the worst-case conversion time plus a margin, the sequencer gives a timeout strobe instead and returns to idle. Every interval is a cycle count derived at elaboration from the system clock frequency, by rounding the stated time up to whole clocks.

Top module: `sh_conv_sequencer`

## Requirements
- R1: During and right after reset, the block is idle. The sample control line is low (sample), the start pulse is low, busy, valid and timeout are low, and the held data word is zero.
- R2: A trigger accepted in idle raises busy on the next cycle. The sample control line then stays low for exactly ceil(ACQ_NS * CLK_HZ / 1e9) cycles.
- R3: When long_acq_i is 1 at the trigger, the acquisition window is ceil(ACQ_LONG_NS * CLK_HZ / 1e9) cycles instead.
- R4: After acquisition, the sample control line goes high (hold) and stays high for ceil(SETTLE_NS * CLK_HZ / 1e9) cycles before the start pulse rises.
- R5: The start pulse is high (active high) for exactly ceil(START_NS * CLK_HZ / 1e9) cycles, with the sample control line high throughout.
- R6: Completion is the status input seen low on a clock edge after it has been seen high at least once since the start pulse rose. A status that is low when the start pulse is issued, or stays low, is never taken as completion.
- R7: On completion, sample_valid_o is high for one cycle. With true_code_i = 0, sample_data_o equals the data lines as sampled on the completion edge; with true_code_i = 1, every one of the 12 bits is inverted.
- R8: sample_data_o keeps its value until the next completion; a timeout or a change on the data lines leaves it unchanged.
- R9: If no completion occurs within ceil((EOC_MAX_NS + EOC_MARGIN_NS) * CLK_HZ / 1e9) cycles after the start pulse falls, timeout_o is high for one cycle and no valid strobe is given.
- R10: If completion falls on the last cycle of the timeout window, completion wins: a valid strobe is given and no timeout.
- R11: A trigger that arrives while busy is ignored. It neither restarts nor lengthens the current cycle and does not start another one.
- R12: In the cycle where the valid or timeout strobe is high, busy is already low and the sample control line is back low (sample).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Conversion request, taken only while idle |
| long_acq_i | input | 1 | Selects the long acquisition window |
| true_code_i | input | 1 | 1 inverts all data bits on capture |
| eoc_i | input | 1 | Converter status: high while busy, low when done |
| conv_data_i | input | 12 | Converter parallel data lines |
| sample_hold_o | output | 1 | Sample control: 0 sample, 1 hold |
| start_conv_o | output | 1 | Start-convert pulse, active high |
| busy_o | output | 1 | High from trigger acceptance until the outcome strobe |
| sample_valid_o | output | 1 | One-cycle strobe with a new data word |
| sample_data_o | output | 12 | Latched conversion result |
| timeout_o | output | 1 | One-cycle strobe when completion never came |

## Verification
Completion detection and the timeout counter can both fire on the same clock edge. The bench's converter model is set so that the status falls exactly on the last allowed cycle of the window. There the bench expects a valid strobe carrying the right data and no timeout. It then shifts the fall one cycle later and expects a timeout, no strobe, and an unchanged data word. Acquisition, settling, pulse and wait lengths are measured one cycle at a time and compared with values computed from the clock frequency.

// File: rtl/sh_adc_pkg.sv
package sh_adc_pkg;

    parameter int unsigned CODE_W = 12;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ACQ    = 3'd1,
        ST_SETTLE = 3'd2,
        ST_START  = 3'd3,
        ST_WAIT   = 3'd4
    } seq_state_t;

    // Round a time in nanoseconds up to whole clock cycles, at least one.
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return 32'(c);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/shc_interval_timer.sv
module shc_interval_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/shc_eoc_qualifier.sv
module shc_eoc_qualifier (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic watch,
    input  logic in_wait,
    input  logic eoc_i,
    output logic done
);
    // Set once the status has been seen high in this cycle.
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed_q <= 1'b0;
        end else if (watch && eoc_i) begin
            armed_q <= 1'b1;
        end
    end

    assign done = in_wait && armed_q && !eoc_i;
endmodule

// File: rtl/shc_result_reg.sv
module shc_result_reg
    import sh_adc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  capture,
    input  logic  true_code,
    input  code_t raw,
    output code_t data_o,
    output logic  valid_o
);
    code_t recoded;

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        assign recoded[b] = raw[b] ^ true_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= capture;
            if (capture) data_o <= recoded;
        end
    end
endmodule

// File: rtl/sh_conv_sequencer.sv
module sh_conv_sequencer
    import sh_adc_pkg::*;
#(
    parameter longint unsigned CLK_HZ        = 100_000_000,
    parameter longint unsigned ACQ_NS        = 6_000,
    parameter longint unsigned ACQ_LONG_NS   = 25_000,
    parameter longint unsigned SETTLE_NS     = 1_000,
    parameter longint unsigned START_NS      = 100,
    parameter longint unsigned EOC_MAX_NS    = 9_000,
    parameter longint unsigned EOC_MARGIN_NS = 2_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trig_i,
    input  logic                long_acq_i,
    input  logic                true_code_i,
    input  logic                eoc_i,
    input  logic [CODE_W-1:0]   conv_data_i,
    output logic                sample_hold_o,
    output logic                start_conv_o,
    output logic                busy_o,
    output logic                sample_valid_o,
    output logic [CODE_W-1:0]   sample_data_o,
    output logic                timeout_o
);
    localparam int unsigned N_ACQ    = ns_to_cycles(ACQ_NS, CLK_HZ);
    localparam int unsigned N_ACQ_L  = ns_to_cycles(ACQ_LONG_NS, CLK_HZ);
    localparam int unsigned N_SETTLE = ns_to_cycles(SETTLE_NS, CLK_HZ);
    localparam int unsigned N_START  = ns_to_cycles(START_NS, CLK_HZ);
    localparam int unsigned N_TMO    = ns_to_cycles(EOC_MAX_NS + EOC_MARGIN_NS, CLK_HZ);
    localparam int unsigned N_MAX    = max_u(max_u(N_ACQ, N_ACQ_L),
                                             max_u(max_u(N_SETTLE, N_START), N_TMO));
    localparam int unsigned TW       = $clog2(N_MAX + 1);

    seq_state_t    state_q, state_d;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic          conv_done, capture, tmo_hit, timeout_q;

    shc_interval_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    shc_eoc_qualifier u_qual (
        .clk     (clk),
        .rst     (rst),
        .clear   (state_q == ST_IDLE),
        .watch   ((state_q == ST_START) || (state_q == ST_WAIT)),
        .in_wait (state_q == ST_WAIT),
        .eoc_i   (eoc_i),
        .done    (conv_done)
    );

    shc_result_reg u_result (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .true_code (true_code_i),
        .raw       (conv_data_i),
        .data_o    (sample_data_o),
        .valid_o   (sample_valid_o)
    );

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        tmo_hit  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_i) begin
                    state_d  = ST_ACQ;
                    tmr_load = 1'b1;
                    tmr_val  = long_acq_i ? TW'(N_ACQ_L - 1) : TW'(N_ACQ - 1);
                end
            end
            ST_ACQ: begin
                if (tmr_expired) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(N_SETTLE - 1);
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    state_d  = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(N_START - 1);
                end
            end
            ST_START: begin
                if (tmr_expired) begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(N_TMO - 1);
                end
            end
            ST_WAIT: begin
                // A completion on the final window cycle takes priority.
                if (conv_done) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                end else if (tmr_expired) begin
                    state_d = ST_IDLE;
                    tmo_hit = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            timeout_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            timeout_q <= tmo_hit;
        end
    end

    assign sample_hold_o = (state_q == ST_SETTLE) || (state_q == ST_START) ||
                           (state_q == ST_WAIT);
    assign start_conv_o  = (state_q == ST_START);
    assign busy_o        = (state_q != ST_IDLE);
    assign timeout_o     = timeout_q;
endmodule

// File: rtl/shc_checker.sv
module shc_checker
    import sh_adc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        sample_hold_o,
    input logic        start_conv_o,
    input logic        busy_o,
    input logic        sample_valid_o,
    input logic        timeout_o,
    input logic [CODE_W-1:0] sample_data_o
);
    assert_enter_sampling_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !sample_hold_o);

    assert_start_after_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(start_conv_o) |-> $past(sample_hold_o));

    assert_start_in_hold_R5: assert property (@(posedge clk) disable iff (rst)
        start_conv_o |-> sample_hold_o);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |=> !sample_valid_o);

    assert_data_held_R8: assert property (@(posedge clk) disable iff (rst)
        !sample_valid_o |-> $stable(sample_data_o));

    assert_timeout_single_R9: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        !(sample_valid_o && timeout_o));

    assert_idle_on_outcome_R12: assert property (@(posedge clk) disable iff (rst)
        (sample_valid_o || timeout_o) |-> (!busy_o && !sample_hold_o));

    assert_idle_samples_R12: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !sample_hold_o);
endmodule

bind sh_conv_sequencer shc_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .sample_hold_o  (sample_hold_o),
    .start_conv_o   (start_conv_o),
    .busy_o         (busy_o),
    .sample_valid_o (sample_valid_o),
    .timeout_o      (timeout_o),
    .sample_data_o  (sample_data_o)
);

// File: tb/sh_conv_sequencer_test.sv
module sh_conv_sequencer_test;
    localparam int  CLK_PERIOD = 10;
    localparam longint unsigned HZ = 20_000_000;
    // Expected cycle counts, from the requirement formulas at HZ.
    localparam int E_ACQ    = int'((6000   * HZ + 999_999_999) / 1_000_000_000);
    localparam int E_ACQ_L  = int'((25000  * HZ + 999_999_999) / 1_000_000_000);
    localparam int E_SETTLE = int'((1000   * HZ + 999_999_999) / 1_000_000_000);
    localparam int E_START  = int'((100    * HZ + 999_999_999) / 1_000_000_000);
    localparam int E_TMO    = int'((11000  * HZ + 999_999_999) / 1_000_000_000);
    localparam logic [11:0] JUNK = 12'hA5A;

    logic clk = 1'b0, rst = 1'b1;
    logic trig_i = 1'b0, long_acq_i = 1'b0, true_code_i = 1'b0;
    logic eoc_i = 1'b0;
    logic [11:0] conv_data_i = 12'h000;
    logic sample_hold_o, start_conv_o, busy_o, sample_valid_o, timeout_o;
    logic [11:0] sample_data_o;

    int checks = 0, errors = 0, cyc = 0;
    logic [11:0] last_data = 12'h000;

    // converter model controls: mode 0 normal, 1 stale-low then delayed rise, 2 never responds
    int mdl_mode = 0, mdl_dly = 0, mdl_conv = 30, mdl_c = 0;
    logic mdl_started = 1'b0;
    logic [11:0] mdl_code = 12'h000;

    always #(CLK_PERIOD/2) clk = ~clk;

    sh_conv_sequencer #(.CLK_HZ(HZ)) uut (
        .clk(clk), .rst(rst), .trig_i(trig_i), .long_acq_i(long_acq_i),
        .true_code_i(true_code_i), .eoc_i(eoc_i), .conv_data_i(conv_data_i),
        .sample_hold_o(sample_hold_o), .start_conv_o(start_conv_o), .busy_o(busy_o),
        .sample_valid_o(sample_valid_o), .sample_data_o(sample_data_o), .timeout_o(timeout_o)
    );

    always @(negedge clk) begin
        if (start_conv_o) begin
            mdl_c       <= 0;
            mdl_started <= 1'b1;
            eoc_i       <= (mdl_mode == 0);
            conv_data_i <= mdl_code ^ JUNK;
        end else if (sample_hold_o && mdl_started) begin
            mdl_c <= mdl_c + 1;
            if (mdl_mode == 1 && mdl_c + 1 == mdl_dly) eoc_i <= 1'b1;
            if (mdl_mode != 2 && mdl_c + 1 == mdl_dly + mdl_conv) begin
                eoc_i       <= 1'b0;
                conv_data_i <= mdl_code;
            end
        end else if (!sample_hold_o) begin
            mdl_c       <= 0;
            mdl_started <= 1'b0;
            eoc_i       <= 1'b0;
            conv_data_i <= mdl_code ^ JUNK;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog all requirements cycles=%0d expected <150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks = checks + 1;
        if (got != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d (0x%0h) expected %0d (0x%0h)", req, got, got, exp, exp);
        end
    endtask

    task automatic run_conv(input logic [11:0] code, input logic tc, input logic lng,
                            input int mode, input int dly, input int conv, input logic poke);
        int acq = 0, setl = 0, st = 0, wt = 0, guard = 0, total, exp_wt;
        logic seen_start = 1'b0, exp_valid;
        logic [11:0] exp_data;
        mdl_mode = mode; mdl_dly = dly; mdl_conv = conv; mdl_code = code;
        true_code_i = tc; long_acq_i = lng;
        @(negedge clk); trig_i = 1'b1;
        @(negedge clk); trig_i = 1'b0;
        chk("R2 busy after trigger", int'(busy_o), 1);
        while (busy_o && guard < 5000) begin
            if (!sample_hold_o) acq++;
            else if (start_conv_o) begin st++; seen_start = 1'b1; end
            else if (!seen_start) setl++;
            else wt++;
            trig_i = (poke && acq == 3 && !sample_hold_o);
            @(negedge clk); guard++;
        end
        trig_i = 1'b0;
        total = dly + conv;
        exp_valid = (mode != 2) && (total <= E_TMO);
        exp_wt = exp_valid ? total : E_TMO;
        exp_data = exp_valid ? (tc ? ~code : code) : last_data;
        if (lng) chk("R3 long acquisition cycles", acq, E_ACQ_L);
        else     chk("R2 acquisition cycles", acq, E_ACQ);
        chk("R4 settle cycles in hold", setl, E_SETTLE);
        chk("R5 start pulse cycles", st, E_START);
        if (mode == 1) chk("R6 stale status not taken as done", wt, exp_wt);
        else if (exp_valid) chk("R10 completion wait cycles", wt, exp_wt);
        else chk("R9 timeout window cycles", wt, exp_wt);
        chk("R7 valid strobe", int'(sample_valid_o), int'(exp_valid));
        chk("R9 timeout strobe", int'(timeout_o), int'(!exp_valid));
        chk("R12 hold released at outcome", int'(sample_hold_o), 0);
        if (exp_valid) chk("R7 latched data", int'(sample_data_o), int'(exp_data));
        else chk("R8 data kept after timeout", int'(sample_data_o), int'(exp_data));
        last_data = exp_data;
        repeat (4) @(negedge clk);
        chk("R7 valid one cycle", int'(sample_valid_o), 0);
        chk("R11 no new cycle from ignored trigger", int'(busy_o), 0);
        chk("R8 data held with bus changed", int'(sample_data_o), int'(last_data));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 hold line", int'(sample_hold_o), 0);
        chk("R1 start", int'(start_conv_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 valid", int'(sample_valid_o), 0);
        chk("R1 timeout", int'(timeout_o), 0);
        chk("R1 data", int'(sample_data_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", int'(busy_o), 0);

        // Sweep of code patterns under both codings, with late triggers on alternate runs.
        for (int i = 0; i < 18; i++) begin
            logic [11:0] code;
            if (i < 12) code = 12'(1) << i;
            else case (i)
                12: code = 12'h000; 13: code = 12'hFFF; 14: code = 12'h800;
                15: code = 12'h7FF; 16: code = 12'h555; default: code = 12'hAAA;
            endcase
            for (int t = 0; t < 2; t++) run_conv(code, t[0], 1'b0, 0, 0, 30 + i, i[0]);
        end
        // R3 long acquisition
        run_conv(12'h3C5, 1'b0, 1'b1, 0, 0, 25, 1'b1);
        run_conv(12'h3C5, 1'b1, 1'b1, 0, 0, 25, 1'b0);
        // R6 status low at start, rises later
        run_conv(12'h123, 1'b0, 1'b0, 1, 15, 20, 1'b0);
        run_conv(12'h456, 1'b1, 1'b0, 1, 40, 1, 1'b0);
        // R6 / R9 / R8 converter never responds
        run_conv(12'hBEE, 1'b0, 1'b0, 2, 0, 30, 1'b0);
        // R10 completion on last window cycle, then one cycle late
        run_conv(12'h9D2, 1'b0, 1'b0, 0, 0, E_TMO, 1'b0);
        run_conv(12'h1F0, 1'b1, 1'b0, 0, 0, E_TMO + 1, 1'b0);
        run_conv(12'h0E7, 1'b1, 1'b0, 1, 100, E_TMO - 100, 1'b0);
        run_conv(12'h064, 1'b0, 1'b0, 0, 0, 1, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule